// File: doc/BRIEF.md
# Radix-2 DIF Butterfly with Three-Multiplier Twiddle Product

This block is one radix-2 decimation-in-frequency butterfly for a pipelined FFT datapath. Each cycle it may accept a pair of complex fixed-point samples `x` and `y` together with a complex twiddle `w`. It returns the sum `x+y` on its upper output and the rotated difference `(x-y)*w` on its lower output. All values are signed fixed point. The twiddle is read as a Q1.(W-1) fraction, so the full-precision product is shifted right by W-1 to return it to sample scale.

The complex rotation needs only three real multipliers. With `a+jb = x-y` and `c+jd = w`, the block forms three terms: `k1 = c(a+b)`, `k2 = a(d-c)` and `k3 = b(c+d)`. The real part is `k1-k3` and the imaginary part is `k1+k2`. The pipeline has three register stages. Stage one does the butterfly add/subtract and the one-bit-wider pre-additions. Stage two does the three multiplies. Stage three does the post-additions and scaling. The sum path is delayed to match, so both outputs and `out_valid` appear together. A parameter `SCALE` adds a common arithmetic right shift to both outputs, which gives per-stage scaling in a cascade. Rounding is truncation toward minus infinity.

Top module: `dif_bfly3m`

## Requirements
- R1: When `out_valid` is high, `sum_re` equals floor((x_re+y_re) / 2^SCALE) and `sum_im` equals floor((x_im+y_im) / 2^SCALE), taken from the operands accepted three cycles earlier. Each is sign-extended to W+2 bits.
- R2: When `out_valid` is high, `dif_re` equals floor(((x_re-y_re)*w_re - (x_im-y_im)*w_im) / 2^(W-1+SCALE)).
- R3: When `out_valid` is high, `dif_im` equals floor(((x_re-y_re)*w_im + (x_im-y_im)*w_re) / 2^(W-1+SCALE)).
- R4: `out_valid` is high exactly three clock cycles after `in_valid` was high. Both the sum and the difference results of one operand set are presented in that same cycle.
- R5: A new operand set can be accepted on every clock cycle. Back-to-back inputs produce back-to-back, in-order results.
- R6: While `rst_n` is low, `out_valid` is low. After reset is released, it stays low until a valid input has passed through the three stages.
- R7: A cycle with `in_valid` low produces a cycle with `out_valid` low three cycles later, whatever data accompanies it.
- R8: Full-scale operands, including -2^(W-1) on any input and a twiddle of -1-1j, give the exact results of R1 to R3 with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Operands on the input ports are valid this cycle |
| x_re | input | W | Upper input sample, real part, signed |
| x_im | input | W | Upper input sample, imaginary part, signed |
| y_re | input | W | Lower input sample, real part, signed |
| y_im | input | W | Lower input sample, imaginary part, signed |
| w_re | input | W | Twiddle real part, signed Q1.(W-1) |
| w_im | input | W | Twiddle imaginary part, signed Q1.(W-1) |
| out_valid | output | 1 | Results on the output ports are valid |
| sum_re | output | W+2 | Scaled real part of x+y |
| sum_im | output | W+2 | Scaled imaginary part of x+y |
| dif_re | output | W+2 | Scaled real part of (x-y)*w |
| dif_im | output | W+2 | Scaled imaginary part of (x-y)*w |

## Verification
The bench builds two copies with W=12: one with SCALE=1 and one with SCALE=0. Both are fed the same stream. The unscaled copy exposes the full W+2-bit growth of the rotated difference at full-scale corners. The scaled copy checks that the extra shift applies equally to both outputs and still floors negative values. A 12-bit width keeps the extreme operands and twiddles (-2048, 2047, ±1448) easy to reason about, while still using every pre-addition guard bit.

// File: rtl/dif_bfly3m.sv
module dif_bfly3m #(
  parameter int W     = 16,
  parameter int SCALE = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] x_re,
  input  logic signed [W-1:0] x_im,
  input  logic signed [W-1:0] y_re,
  input  logic signed [W-1:0] y_im,
  input  logic signed [W-1:0] w_re,
  input  logic signed [W-1:0] w_im,
  output logic                out_valid,
  output logic signed [W+1:0] sum_re,
  output logic signed [W+1:0] sum_im,
  output logic signed [W+1:0] dif_re,
  output logic signed [W+1:0] dif_im
);

  localparam int OW = W + 2;
  localparam int KW = 2*W + 2;
  localparam int PW = 2*W + 3;
  localparam int SH = W - 1 + SCALE;

  // stage 1: butterfly add/subtract and widened pre-additions
  logic signed [W:0]   s_re_c, s_im_c, d_re_c, d_im_c, dmc_c, cpd_c;
  logic signed [W+1:0] apb_c;

  assign s_re_c = (W+1)'(x_re) + (W+1)'(y_re);
  assign s_im_c = (W+1)'(x_im) + (W+1)'(y_im);
  assign d_re_c = (W+1)'(x_re) - (W+1)'(y_re);
  assign d_im_c = (W+1)'(x_im) - (W+1)'(y_im);
  assign apb_c  = (W+2)'(d_re_c) + (W+2)'(d_im_c);
  assign dmc_c  = (W+1)'(w_im) - (W+1)'(w_re);
  assign cpd_c  = (W+1)'(w_re) + (W+1)'(w_im);

  logic                v1, v2;
  logic signed [W:0]   p_a, p_b, p_dmc, p_cpd, s1_re, s1_im;
  logic signed [W-1:0] p_c;
  logic signed [W+1:0] p_apb;

  // stage 2: three real multiplies
  logic signed [KW-1:0] k1_c, k2_c, k3_c;
  logic signed [KW-1:0] k1_q, k2_q, k3_q;
  logic signed [W:0]    s2_re, s2_im;

  assign k1_c = KW'(p_c) * KW'(p_apb);
  assign k2_c = KW'(p_a) * KW'(p_dmc);
  assign k3_c = KW'(p_b) * KW'(p_cpd);

  // stage 3: post-additions and scaling
  logic signed [PW-1:0] re_full, im_full;

  assign re_full = PW'(k1_q) - PW'(k3_q);
  assign im_full = PW'(k1_q) + PW'(k2_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1        <= in_valid;
      v2        <= v1;
      out_valid <= v2;
    end
  end

  always_ff @(posedge clk) begin
    p_a    <= d_re_c;
    p_b    <= d_im_c;
    p_c    <= w_re;
    p_apb  <= apb_c;
    p_dmc  <= dmc_c;
    p_cpd  <= cpd_c;
    s1_re  <= s_re_c;
    s1_im  <= s_im_c;
    k1_q   <= k1_c;
    k2_q   <= k2_c;
    k3_q   <= k3_c;
    s2_re  <= s1_re;
    s2_im  <= s1_im;
    sum_re <= OW'(s2_re) >>> SCALE;
    sum_im <= OW'(s2_im) >>> SCALE;
    dif_re <= OW'(re_full >>> SH);
    dif_im <= OW'(im_full >>> SH);
  end

  // checking: direct four-multiply reference from the ports, compared three cycles later
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  logic signed [PW-1:0] ref_re, ref_im, ref_sre, ref_sim;
  assign ref_re  = PW'(d_re_c) * PW'(w_re) - PW'(d_im_c) * PW'(w_im);
  assign ref_im  = PW'(d_re_c) * PW'(w_im) + PW'(d_im_c) * PW'(w_re);
  assign ref_sre = PW'(x_re) + PW'(y_re);
  assign ref_sim = PW'(x_im) + PW'(y_im);

  a_r1_sum_value: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_valid) |->
      (sum_re == OW'($past(ref_sre, 3) >>> SCALE) && sum_im == OW'($past(ref_sim, 3) >>> SCALE)));

  a_r2_dif_real: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_valid) |-> dif_re == OW'($past(ref_re, 3) >>> SH));

  a_r3_dif_imag: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_valid) |-> dif_im == OW'($past(ref_im, 3) >>> SH));

  a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> out_valid == $past(in_valid, 3));

  a_r6_reset_clear: assert property (@(posedge clk) !rst_n |-> !out_valid);

endmodule

// File: tb/tb_dif_bfly3m.sv
`timescale 1ns/1ps
module tb_dif_bfly3m;
  localparam int W = 12;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [W-1:0] x_re = '0, x_im = '0, y_re = '0, y_im = '0, w_re = '0, w_im = '0;
  logic ov1, ov0;
  logic signed [W+1:0] sr1, si1, dr1, di1, sr0, si0, dr0, di0;

  always #2.5 clk = ~clk;

  dif_bfly3m #(.W(W), .SCALE(1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im), .w_re(w_re), .w_im(w_im),
    .out_valid(ov1), .sum_re(sr1), .sum_im(si1), .dif_re(dr1), .dif_im(di1));

  dif_bfly3m #(.W(W), .SCALE(0)) dut_ns (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im), .w_re(w_re), .w_im(w_im),
    .out_valid(ov0), .sum_re(sr0), .sum_im(si0), .dif_re(dr0), .dif_im(di0));

  // columns: x_re, x_im, y_re, y_im, w_re, w_im
  localparam logic signed [W-1:0] TV [N][6] = '{
    '{  100,     0,    20,     0,  2047,     0},
    '{  300,  -200,  -100,    50,  1448, -1448},
    '{    0,     0,     0,     0,     0,     0},
    '{ 2047,  2047, -2048, -2048,  2047,     0},
    '{-2048, -2048,  2047,  2047, -2048, -2048},
    '{ 2047, -2048, -2048,  2047,     0, -2048},
    '{   -1,    -1,     0,     0,     1,     1},
    '{ 1000, -1000,  1000, -1000,  1448,  1448},
    '{    5,     7,     3,     1, -1448,  1448},
    '{ -777,   333,   222,  -999, -1448, -1448},
    '{ 1234,  -567,  -890,   123,  2047,  2047},
    '{ 2047,  2047,  2047,  2047, -2048,  2047}
  };
  localparam bit TVV [N] = '{1, 1, 0, 1, 1, 1, 1, 1, 0, 1, 1, 1};

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint e_sum(int k, int comp, int sc);
    longint a = TV[k][comp];
    longint b = TV[k][comp+2];
    return (a + b) >>> sc;
  endfunction

  function automatic longint e_dif(int k, bit imag, int sc);
    longint ar = TV[k][0] - TV[k][2];
    longint ai = TV[k][1] - TV[k][3];
    longint c  = TV[k][4];
    longint d  = TV[k][5];
    longint p  = imag ? (ar*d + ai*c) : (ar*c - ai*d);
    return p >>> (W - 1 + sc);
  endfunction

  task automatic check_vec(int k);
    string t2 = (k >= 3 && k <= 5) ? "R8 dif_re" : "R2 dif_re";
    string t3 = (k >= 3 && k <= 5) ? "R8 dif_im" : "R3 dif_im";
    chk(TVV[k] ? "R5 out_valid" : "R7 out_valid", longint'(ov1), longint'(TVV[k]));
    chk(TVV[k] ? "R5 out_valid ns" : "R7 out_valid ns", longint'(ov0), longint'(TVV[k]));
    if (TVV[k]) begin
      chk("R1 sum_re", longint'(sr1), e_sum(k, 0, 1));
      chk("R1 sum_im", longint'(si1), e_sum(k, 1, 1));
      chk(t2, longint'(dr1), e_dif(k, 1'b0, 1));
      chk(t3, longint'(di1), e_dif(k, 1'b1, 1));
      chk("R1 sum_re ns", longint'(sr0), e_sum(k, 0, 0));
      chk("R1 sum_im ns", longint'(si0), e_sum(k, 1, 0));
      chk({t2, " ns"}, longint'(dr0), e_dif(k, 1'b0, 0));
      chk({t3, " ns"}, longint'(di0), e_dif(k, 1'b1, 0));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 out_valid in reset", longint'(ov1), 0);
    chk("R6 out_valid in reset ns", longint'(ov0), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 out_valid after release", longint'(ov1), 0);

    // table walk, one vector per cycle; vector k appears three negedges later
    for (int j = 0; j < N + 3; j++) begin
      @(negedge clk);
      if (j >= 3) check_vec(j - 3);
      if (j < N) begin
        x_re = TV[j][0]; x_im = TV[j][1]; y_re = TV[j][2];
        y_im = TV[j][3]; w_re = TV[j][4]; w_im = TV[j][5];
        in_valid = TVV[j];
      end else begin
        in_valid = 1'b0;
      end
    end

    // single pulse latency
    @(negedge clk);
    x_re = 12; x_im = -5; y_re = 4; y_im = 3; w_re = 2047; w_im = 0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 latency cycle 1", longint'(ov1), 0);
    @(negedge clk);
    chk("R4 latency cycle 2", longint'(ov1), 0);
    @(negedge clk);
    chk("R4 latency cycle 3", longint'(ov1), 1);
    chk("R4 same-cycle sum_re", longint'(sr1), 8);
    chk("R4 same-cycle dif_re", longint'(dr1), ((longint'(8) * 2047) >>> 12));
    @(negedge clk);
    chk("R4 latency cycle 4", longint'(ov1), 0);

    // reset in mid-stream
    in_valid = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R6 async clear", longint'(ov1), 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R6 quiet after reset", longint'(ov1), 0);
      chk("R6 quiet after reset ns", longint'(ov0), 0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      repeat (5000) @(posedge clk);
    join_any
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule